// File: doc/BRIEF.md
# Synchronizer Mode and Reference Selection Controller

This block is the control state machine of a telecom clock synchronizer. It watches three candidate timing references and keeps one of them selected. It walks the loop through four operating modes: free-run, lock acquisition, normal (locked) and holdover. The phase detector, loop filter and oscillator are outside the block. A `lock_i` input stands in for the loop's report that phase lock has been reached.

Each reference has four failure flags from its monitors: single-cycle, coarse frequency, precise frequency and guard-soak. A shared mask decides which of these flags count. A reference that has failed only becomes usable again after a wait-to-restore period, counted in pulses of a slow tick input.

In automatic selection the usable reference with the lowest priority value is chosen. A healthy selected reference is displaced only by a strictly better reference that has its revertive flag set. In manual selection the software-chosen index is used as given.

The level on a mode pin is sampled around reset. A low level pins the controller in free-run. A forced-mode input overrides the state machine at any time. Every change of mode or selected reference raises a one-cycle event pulse for an interrupt controller.

Top module: `sync_ref_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `mode_o` is 0 (free-run) and `ref_sel_o`, `lock_o`, `holdover_o` and `event_o` are 0. The mode stays free-run as long as no reference is usable.
- R2: From free-run, the first edge at which some reference is usable moves `mode_o` to 1 (acquisition), with `ref_sel_o` pointing at the chosen usable reference.
- R3: From acquisition, `lock_i` high moves `mode_o` to 2 (normal) at the next edge. `lock_o` is high exactly when `mode_o` is 2, and `holdover_o` is high exactly when `mode_o` is 3.
- R4: In normal mode, if the selected reference stops being usable:
  - When another reference is usable, the block selects it and returns to acquisition.
  - When none is usable, it enters holdover (3) and keeps the old index.
  - From holdover, it returns to acquisition as soon as a reference is usable.
- R5: `mode_pin_i` is sampled while reset is low and on the first cycle after reset. With the pin low, the mode stays free-run. With `force_en_i` high, `mode_o` takes `force_mode_i` one edge later, using the encoding 0 free-run, 1 acquisition, 2 normal, 3 holdover.
- R6: Automatic selection picks the usable reference with the lowest priority value. Priority n sits at `prio_i[2n+1:2n]`. Ties go to the lowest index.
- R7: Reference n is usable only if no failure bit in `fail_i[4n+3:4n]` is set whose mask bit is clear. The bit order in each group is single-cycle (bit 0), coarse (bit 1), precise (bit 2) and guard-soak (bit 3). A set bit in `fail_mask_i` ignores that source for all three references.
- R8: A healthy selected reference is replaced only by a reference with a strictly lower priority value whose bit in `revert_en_i` is set. Such a swap in normal mode returns the block to acquisition.
- R9: After a failure, a reference stays unusable until `wtr_time_i` pulses of `tick_i` have been counted while it is healthy. A value of 0 makes it usable in the same cycle its failures clear.
- R10: `event_o` is high for exactly the cycles in which `mode_o` or `ref_sel_o` shows a new value.
- R11: With `manual_en_i` high, `ref_sel_o` follows `manual_ref_i` (values 0 to 2; the value 3 is ignored) and no automatic switching occurs. A failed manual reference leads from normal into holdover.
- R12: If `lock_i` is high in acquisition in the same cycle the selection changes, the block stays in acquisition on the new reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_pin_i | input | 1 | Default-mode pin sampled around reset (1 automatic, 0 free-run) |
| force_en_i | input | 1 | Force the mode to `force_mode_i` |
| force_mode_i | input | 2 | Forced mode code |
| manual_en_i | input | 1 | Manual reference selection |
| manual_ref_i | input | 2 | Manually chosen reference index |
| fail_i | input | 12 | Four failure flags per reference |
| fail_mask_i | input | 4 | Per-source failure mask, 1 = ignore |
| prio_i | input | 6 | Two-bit priority per reference, lower wins |
| revert_en_i | input | 3 | Revertive enable per reference |
| wtr_time_i | input | 8 | Wait-to-restore length in ticks |
| tick_i | input | 1 | Slow timing tick |
| lock_i | input | 1 | Phase lock reported by the loop |
| mode_o | output | 2 | Operating mode |
| ref_sel_o | output | 2 | Selected reference index |
| lock_o | output | 1 | Lock indicator |
| holdover_o | output | 1 | Holdover indicator |
| event_o | output | 1 | One-cycle pulse on a mode or selection change |

## Verification
The collision of interest is a lock report from the loop arriving in the same cycle as a reference change, R12. The bench provokes it by holding `lock_i` high while the block is in acquisition on one reference, and failing that reference in the same cycle. The scoreboard then expects acquisition on the next best reference for one cycle, rather than normal mode, and normal mode one edge later. A second overlap is a failure and a revertive swap pending together on the same edge. The bench judges it by the index and the event pulse that appear at the next edge.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;
  localparam int FAIL_SRCS = 4;

  typedef enum logic [1:0] {
    MODE_FREERUN  = 2'd0,
    MODE_ACQUIRE  = 2'd1,
    MODE_LOCKED   = 2'd2,
    MODE_HOLDOVER = 2'd3
  } sync_mode_e;
endpackage

// File: rtl/sync_ref_qual.sv
module sync_ref_qual
  import sync_ctrl_pkg::*;
#(
  parameter int WTR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [FAIL_SRCS-1:0] fail_i,
  input  logic [FAIL_SRCS-1:0] fail_mask_i,
  input  logic [WTR_W-1:0]     wtr_i,
  input  logic                 tick_i,
  output logic                 avail_o
);
  logic             raw_ok;
  logic             held_q;
  logic [WTR_W-1:0] cnt_q;

  assign raw_ok  = ~|(fail_i & ~fail_mask_i);
  assign avail_o = raw_ok & (~held_q | (cnt_q >= wtr_i));

  // restore timer: restarts on every failure, counts ticks only while healthy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!raw_ok) begin
      held_q <= 1'b1;
      cnt_q  <= '0;
    end else if (held_q) begin
      if (cnt_q >= wtr_i) held_q <= 1'b0;
      else if (tick_i)    cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_WTR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_ok && wtr_i != '0) |=> (!avail_o || wtr_i == '0)); // R9
endmodule

// File: rtl/sync_ref_pick.sv
module sync_ref_pick #(
  parameter int NUM_REFS = 3,
  parameter int PRIO_W   = 2,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_REFS-1:0]        avail_i,
  input  logic [NUM_REFS*PRIO_W-1:0] prio_i,
  output logic                       any_o,
  output logic [IDX_W-1:0]           best_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    any_o     = 1'b0;
    best_o    = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (avail_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        any_o     = 1'b1;
        best_o    = IDX_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
  import sync_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_i,
  input  logic       force_en_i,
  input  sync_mode_e force_mode_i,
  input  logic       sel_ok_i,
  input  logic       sel_change_i,
  input  logic       lock_i,
  output sync_mode_e mode_o,
  output sync_mode_e mode_next_o,
  output logic       lock_o,
  output logic       holdover_o
);
  sync_mode_e mode_q, nxt;
  logic       ever_q;

  always_comb begin
    nxt = mode_q;
    if (force_en_i)   nxt = force_mode_i;
    else if (!auto_i) nxt = MODE_FREERUN;
    else begin
      unique case (mode_q)
        MODE_FREERUN:  if (sel_ok_i) nxt = MODE_ACQUIRE;
        MODE_ACQUIRE: begin
          if (!sel_ok_i)                     nxt = ever_q ? MODE_HOLDOVER : MODE_FREERUN;
          else if (lock_i && !sel_change_i)  nxt = MODE_LOCKED;
        end
        MODE_LOCKED: begin
          if (!sel_ok_i)         nxt = MODE_HOLDOVER;
          else if (sel_change_i) nxt = MODE_ACQUIRE;
        end
        MODE_HOLDOVER: if (sel_ok_i) nxt = MODE_ACQUIRE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_FREERUN;
      ever_q     <= 1'b0;
      lock_o     <= 1'b0;
      holdover_o <= 1'b0;
    end else begin
      mode_q     <= nxt;
      ever_q     <= ever_q | (mode_q == MODE_LOCKED);
      lock_o     <= (nxt == MODE_LOCKED);
      holdover_o <= (nxt == MODE_HOLDOVER);
    end
  end

  assign mode_o      = mode_q;
  assign mode_next_o = nxt;

  AST_LOCK_IND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o == (mode_q == MODE_LOCKED)); // R3
  AST_HOLD_IND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdover_o == (mode_q == MODE_HOLDOVER)); // R3
  AST_FREERUN_VIA_ACQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FREERUN && !force_en_i)
      |=> (mode_q != MODE_LOCKED && mode_q != MODE_HOLDOVER)); // R2
  AST_SWITCH_BEATS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && !force_en_i && mode_q == MODE_ACQUIRE && sel_change_i)
      |=> mode_q != MODE_LOCKED); // R12
endmodule

// File: rtl/sync_ref_ctrl.sv
module sync_ref_ctrl
  import sync_ctrl_pkg::*;
#(
  parameter int NUM_REFS = 3,
  parameter int PRIO_W   = 2,
  parameter int WTR_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REFS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_pin_i,
  input  logic                          force_en_i,
  input  logic [1:0]                    force_mode_i,
  input  logic                          manual_en_i,
  input  logic [IDX_W-1:0]              manual_ref_i,
  input  logic [NUM_REFS*FAIL_SRCS-1:0] fail_i,
  input  logic [FAIL_SRCS-1:0]          fail_mask_i,
  input  logic [NUM_REFS*PRIO_W-1:0]    prio_i,
  input  logic [NUM_REFS-1:0]           revert_en_i,
  input  logic [WTR_W-1:0]              wtr_time_i,
  input  logic                          tick_i,
  input  logic                          lock_i,
  output logic [1:0]                    mode_o,
  output logic [IDX_W-1:0]              ref_sel_o,
  output logic                          lock_o,
  output logic                          holdover_o,
  output logic                          event_o
);
  localparam logic [IDX_W-1:0] LAST_REF = IDX_W'(NUM_REFS - 1);

  logic [NUM_REFS-1:0] avail;
  logic                any_avail;
  logic [IDX_W-1:0]    best, sel_q, sel_d;
  logic [PRIO_W-1:0]   prio_best, prio_sel;
  logic                cap_q, auto_q, auto_eff;
  logic                event_q;
  sync_mode_e          mode_cur, mode_nxt;

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
    sync_ref_qual #(.WTR_W(WTR_W)) u_qual (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fail_i      (fail_i[g*FAIL_SRCS +: FAIL_SRCS]),
      .fail_mask_i (fail_mask_i),
      .wtr_i       (wtr_time_i),
      .tick_i      (tick_i),
      .avail_o     (avail[g])
    );
  end

  sync_ref_pick #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .avail_i (avail),
    .prio_i  (prio_i),
    .any_o   (any_avail),
    .best_o  (best)
  );

  // default mode pin: followed during reset and the first cycle after, then frozen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b1;
      auto_q <= 1'b0;
    end else if (cap_q) begin
      cap_q  <= 1'b0;
      auto_q <= mode_pin_i;
    end
  end
  assign auto_eff = cap_q ? mode_pin_i : auto_q;

  assign prio_best = prio_i[best*PRIO_W +: PRIO_W];
  assign prio_sel  = prio_i[sel_q*PRIO_W +: PRIO_W];

  always_comb begin
    sel_d = sel_q;
    if (manual_en_i) begin
      if (manual_ref_i <= LAST_REF) sel_d = manual_ref_i;
    end else if (any_avail) begin
      if (!avail[sel_q])                                     sel_d = best;
      else if (revert_en_i[best] && (prio_best < prio_sel))  sel_d = best;
    end
  end

  sync_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_i       (auto_eff),
    .force_en_i   (force_en_i),
    .force_mode_i (sync_mode_e'(force_mode_i)),
    .sel_ok_i     (avail[sel_d]),
    .sel_change_i (sel_d != sel_q),
    .lock_i       (lock_i),
    .mode_o       (mode_cur),
    .mode_next_o  (mode_nxt),
    .lock_o       (lock_o),
    .holdover_o   (holdover_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      event_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      event_q <= (mode_nxt != mode_cur) || (sel_d != sel_q);
    end
  end

  assign mode_o    = mode_cur;
  assign ref_sel_o = sel_q;
  assign event_o   = event_q;

  AST_EVENT_ON_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) |-> event_o); // R10
  AST_SEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_sel_o <= LAST_REF); // R6
  AST_NO_REVERT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_en_i && avail[sel_q] && revert_en_i == '0) |=> ref_sel_o == $past(ref_sel_o)); // R8
endmodule

// File: tb/sync_ref_ctrl_test.sv
module sync_ref_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] FR = 2'd0, AQ = 2'd1, LK = 2'd2, HO = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_pin, force_en, manual_en, tick, lock_in;
  logic [1:0]  force_mode, manual_ref;
  logic [11:0] fail;
  logic [3:0]  mask;
  logic [5:0]  prio;
  logic [2:0]  revert;
  logic [7:0]  wtr;
  logic [1:0]  mode_o, ref_sel_o;
  logic        lock_o, holdover_o, event_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ref_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_pin_i(mode_pin),
    .force_en_i(force_en), .force_mode_i(force_mode),
    .manual_en_i(manual_en), .manual_ref_i(manual_ref),
    .fail_i(fail), .fail_mask_i(mask), .prio_i(prio),
    .revert_en_i(revert), .wtr_time_i(wtr), .tick_i(tick), .lock_i(lock_in),
    .mode_o(mode_o), .ref_sel_o(ref_sel_o), .lock_o(lock_o),
    .holdover_o(holdover_o), .event_o(event_o)
  );

  typedef struct {
    logic [1:0] mode;
    logic [1:0] sel;
    logic       lk;
    logic       ho;
    logic       ev;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         fails  = 0;
  logic [1:0] pm, ps;
  bit         done = 0;

  // monitor: compares registered outputs away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if ({mode_o, ref_sel_o, lock_o, holdover_o, event_o} !== {e.mode, e.sel, e.lk, e.ho, e.ev}) begin
        fails++;
        $display("FAIL %s: mode=%0d sel=%0d lock=%0b hold=%0b ev=%0b expected mode=%0d sel=%0d lock=%0b hold=%0b ev=%0b",
                 e.tag, mode_o, ref_sel_o, lock_o, holdover_o, event_o,
                 e.mode, e.sel, e.lk, e.ho, e.ev);
      end
    end
  end

  // driver: one clock edge, expectation pushed for the monitor
  task automatic step(input logic [1:0] m, input logic [1:0] s, input string tag);
    exp_t e;
    @(posedge clk);
    e.mode = m; e.sel = s; e.lk = (m == LK); e.ho = (m == HO);
    e.ev   = (m != pm) || (s != ps);
    e.tag  = tag;
    pm = m; ps = s;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0; mode_pin = pin;
    repeat (3) @(negedge clk);
    checks++;
    if ({mode_o, ref_sel_o, lock_o, holdover_o, event_o} !== 7'b0) begin
      fails++;
      $display("FAIL R1 reset state: got %b expected 0000000",
               {mode_o, ref_sel_o, lock_o, holdover_o, event_o});
    end
    rst_n = 1'b1; pm = FR; ps = 2'd0;
    #1;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got no end expected end");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_pin = 1'b1; force_en = 1'b0; force_mode = 2'd0;
    manual_en = 1'b0; manual_ref = 2'd0; fail = 12'hFFF; mask = 4'h0;
    prio = {2'd2, 2'd1, 2'd0}; revert = 3'b000; wtr = 8'd0; tick = 1'b0; lock_in = 1'b0;

    do_reset(1'b1);
    step(FR, 0, "R1 idle without usable reference");
    step(FR, 0, "R1 idle without usable reference");

    fail[4 +: 4] = 4'h0;
    step(AQ, 1, "R2 acquisition on ref1");
    step(AQ, 1, "R10 event drops when nothing changes");
    lock_in = 1'b1;
    step(LK, 1, "R3 normal after lock report");

    fail[0 +: 4] = 4'h0;
    step(LK, 1, "R8 non-revertive keeps ref1");
    step(LK, 1, "R8 non-revertive keeps ref1");
    revert = 3'b001;
    step(AQ, 0, "R8 revert to better ref0");
    step(LK, 0, "R3 relock on ref0");

    revert = 3'b000; fail[0 +: 4] = 4'b0001;
    step(AQ, 1, "R4 switch away from failed ref0");
    step(LK, 1, "R4 relock on ref1");

    mask = 4'b0001; revert = 3'b001;
    step(AQ, 0, "R7 masked source ignored, R9 zero wait");
    step(LK, 0, "R7 relock on ref0");

    revert = 3'b000; fail = 12'hFFF;
    step(HO, 0, "R4 holdover with no usable reference");
    step(HO, 0, "R3 holdover indicator held");

    wtr = 8'd3; fail[8 +: 4] = 4'h0;
    step(HO, 0, "R9 healthy but waiting");
    tick = 1'b1;
    step(HO, 0, "R9 first tick");
    step(HO, 0, "R9 second tick");
    step(HO, 0, "R9 third tick");
    tick = 1'b0;
    step(AQ, 2, "R9 restored after wait, R4 leaves holdover");
    step(LK, 2, "R3 lock on ref2");

    wtr = 8'd0; fail = 12'hFFF;
    step(HO, 2, "R4 holdover keeps index");
    prio = {2'd0, 2'd1, 2'd1};
    fail[0 +: 4] = 4'h0; fail[4 +: 4] = 4'h0;
    step(AQ, 0, "R6 tie goes to lowest index");
    step(LK, 0, "R6 lock on ref0");
    revert = 3'b100; fail[8 +: 4] = 4'h0;
    step(AQ, 2, "R6 lower priority value wins");
    fail[8 +: 4] = 4'hF;
    step(AQ, 0, "R12 switch beats lock report");
    step(LK, 0, "R12 lock one edge later");

    revert = 3'b000; manual_en = 1'b1; manual_ref = 2'd1;
    step(AQ, 1, "R11 manual pick ref1");
    step(LK, 1, "R11 lock on manual ref");
    manual_ref = 2'd3;
    step(LK, 1, "R11 index 3 ignored");
    fail[4 +: 4] = 4'b0010;
    step(HO, 1, "R11 no automatic switch");
    manual_en = 1'b0;
    step(AQ, 0, "R11 automatic selection resumes");
    step(LK, 0, "R11 relock on ref0");

    force_en = 1'b1; force_mode = 2'd3;
    step(HO, 0, "R5 forced holdover");
    step(HO, 0, "R5 forced holdover held");
    force_en = 1'b0;
    step(AQ, 0, "R5 release of forcing");
    step(LK, 0, "R5 lock after release");

    fail = 12'h000;
    do_reset(1'b0);
    step(FR, 0, "R5 pin low keeps free-run");
    step(FR, 0, "R5 pin low keeps free-run");
    step(FR, 0, "R5 pin low keeps free-run");

    @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule